// File: doc/BRIEF.md
# Self-Timed Flash Operation Sequencer with Interrupt Abort

This block sequences erase, program and CRC cycles on an embedded flash array on behalf of in-application calls. Software presents a start request with an operation type. The block checks write permission for the two modifying operations. It then holds the CPU in a program-idle stall while the cycle runs, and it times that cycle itself from per-operation cycle counts. When the count runs out it releases the stall and reports success.

The CPU cannot fetch instructions from the array while a cycle is running, so an interrupt cannot be serviced until the stall ends. For that reason any interrupt that arrives while an operation runs ends that operation at once and releases the stall. The abort is reported through a carry-style error flag and a status code, and software repeats the operation if it wants it done. After every modifying operation the block sends a one-cycle pulse to the external write-enable guard telling it to drop its enable. This happens whether the operation completed or was aborted.

Top module: `flash_op_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, `stall_o`, `carry_o`, `done_o` and `clr_we_o` are 0 and `status_o` is 0.
- R2: An accepted operation raises `stall_o` at the clock edge that samples `start_i`. The stall lasts exactly the configured number of cycles for its type: `ERASE_CYC` (default 40), `PROG_CYC` (default 12) or `CRC_CYC` (default 6). Operation codes on `op_i` are 0 = erase, 1 = program, 2 = CRC, and 3 = CRC.
- R3: When an operation ends normally, `done_o` is high for exactly one cycle, starting in the cycle in which `stall_o` first reads 0. In that cycle `carry_o` = 0 and `status_o` = 0 (success).
- R4: If `irq_i` is sampled high while `stall_o` is high, the next edge drops `stall_o`, sets `carry_o` = 1 and `status_o` = 1 (aborted), and pulses `done_o`. The operation is not restarted.
- R5: A start request for erase or program while `we_i` = 0 raises no stall. The next cycle shows `carry_o` = 1, `status_o` = 2 (write not enabled) and a one-cycle `done_o`.
- R6: `carry_o` and `status_o` are cleared when an operation is accepted and stay 0 for as long as `stall_o` is high.
- R7: `clr_we_o` pulses for one cycle, together with `done_o`, when an erase or program completes or aborts. It never pulses for CRC or for a rejected request.
- R8: A start request while `stall_o` is high is ignored: the stall length, `arr_op_o` and the result are those of the running operation.
- R9: An interrupt sampled in the final stall cycle aborts the operation (status 1) rather than letting it complete. `irq_i` while idle leaves `carry_o` and `status_o` unchanged.
- R10: `arr_op_o` carries the running operation code for the whole stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 2 | Operation type: 0 erase, 1 program, 2/3 CRC |
| we_i | input | 1 | Write-enable flag from the guard |
| irq_i | input | 1 | Pending interrupt |
| stall_o | output | 1 | CPU program-idle stall, high while a cycle runs |
| arr_op_o | output | 2 | Operation code driven to the array |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| carry_o | output | 1 | Error flag |
| status_o | output | 2 | 0 ok, 1 aborted, 2 write not enabled |
| clr_we_o | output | 1 | One-cycle clear-write-enable pulse to the guard |

## Verification
Each operation type is run to completion with write permission granted. This separates the three cycle counts and shows which types request a write-enable clear. Modifying operations with permission withdrawn show that the rejection path raises no stall. Interrupts placed at random stall cycles, including the first and the last, separate an abort from a completion at the boundary. Stray start requests during a stall and interrupts while idle must leave the result unchanged.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_PROG  = 2'd1,
        OP_CRC   = 2'd2,
        OP_CRC2  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_ABORT = 2'd1,
        ST_NOWE  = 2'd2
    } stat_e;

    typedef struct packed {
        logic  carry;
        stat_e status;
    } result_t;

    function automatic logic is_write(input logic [1:0] op);
        return (op == OP_ERASE) || (op == OP_PROG);
    endfunction

    function automatic int unsigned op_len(input logic [1:0] op,
                                           input int unsigned er,
                                           input int unsigned pr,
                                           input int unsigned cr);
        case (op)
            OP_ERASE: return er;
            OP_PROG:  return pr;
            default:  return cr;
        endcase
    endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import fseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] op,
    input  logic       we,
    input  logic       irq,
    input  logic       expired,
    output logic       load,
    output logic       busy,
    output logic [1:0] op_q,
    output result_t    res,
    output logic       done,
    output logic       clr_we
);
    logic reject;

    always_comb begin
        reject = is_write(op) && !we;
        load   = !busy && start && !reject;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            op_q   <= OP_ERASE;
            res    <= '{carry: 1'b0, status: ST_OK};
            done   <= 1'b0;
            clr_we <= 1'b0;
        end else begin
            done   <= 1'b0;
            clr_we <= 1'b0;
            if (!busy) begin
                if (start) begin
                    if (reject) begin
                        res  <= '{carry: 1'b1, status: ST_NOWE};
                        done <= 1'b1;
                    end else begin
                        busy <= 1'b1;
                        op_q <= op;
                        res  <= '{carry: 1'b0, status: ST_OK};
                    end
                end
            end else if (irq) begin
                busy   <= 1'b0;
                res    <= '{carry: 1'b1, status: ST_ABORT};
                done   <= 1'b1;
                clr_we <= is_write(op_q);
            end else if (expired) begin
                busy   <= 1'b0;
                done   <= 1'b1;
                clr_we <= is_write(op_q);
            end
        end
    end
endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
    import fseq_pkg::*;
#(
    parameter int unsigned ERASE_CYC = 40,
    parameter int unsigned PROG_CYC  = 12,
    parameter int unsigned CRC_CYC   = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic [1:0] op_i,
    input  logic       we_i,
    input  logic       irq_i,
    output logic       stall_o,
    output logic [1:0] arr_op_o,
    output logic       done_o,
    output logic       carry_o,
    output logic [1:0] status_o,
    output logic       clr_we_o
);
    localparam int unsigned MAXC =
        (ERASE_CYC > PROG_CYC) ? ((ERASE_CYC > CRC_CYC) ? ERASE_CYC : CRC_CYC)
                               : ((PROG_CYC > CRC_CYC) ? PROG_CYC : CRC_CYC);
    localparam int W = (MAXC < 2) ? 1 : $clog2(MAXC);

    logic         load, busy, expired, done, clr_we;
    logic [1:0]   op_q;
    logic [W-1:0] load_val;
    result_t      res;

    assign load_val = W'(op_len(op_i, ERASE_CYC, PROG_CYC, CRC_CYC) - 1);

    fseq_timer #(.W(W)) u_timer (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .run(busy), .expired(expired)
    );

    fseq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start_i), .op(op_i), .we(we_i),
        .irq(irq_i), .expired(expired), .load(load), .busy(busy),
        .op_q(op_q), .res(res), .done(done), .clr_we(clr_we)
    );

    assign stall_o  = busy;
    assign arr_op_o = op_q;
    assign done_o   = done;
    assign carry_o  = res.carry;
    assign status_o = res.status;
    assign clr_we_o = clr_we;
endmodule

// File: rtl/fseq_chk.sv
module fseq_chk
    import fseq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [1:0] op_i,
    input logic       we_i,
    input logic       irq_i,
    input logic       stall_o,
    input logic [1:0] arr_op_o,
    input logic       done_o,
    input logic       carry_o,
    input logic [1:0] status_o,
    input logic       clr_we_o
);
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R3
    AST_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(stall_o) |-> done_o);  // R3
    AST_IRQ_ABORT: assert property (@(posedge clk) disable iff (rst)
        (stall_o && irq_i) |=> (!stall_o && carry_o && status_o == 2'd1 && done_o));  // R4
    AST_REJECT_NOWE: assert property (@(posedge clk) disable iff (rst)
        (!stall_o && start_i && op_i[1] == 1'b0 && !we_i)
            |=> (!stall_o && carry_o && status_o == 2'd2));  // R5
    AST_BUSY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (!carry_o && status_o == 2'd0));  // R6
    AST_CLRWE_DONE: assert property (@(posedge clk) disable iff (rst)
        clr_we_o |-> (done_o && arr_op_o[1] == 1'b0 && status_o != 2'd2));  // R7
    AST_OP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_o && $past(stall_o)) |-> $stable(arr_op_o));  // R8
endmodule

bind flash_op_seq fseq_chk u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .we_i(we_i),
    .irq_i(irq_i), .stall_o(stall_o), .arr_op_o(arr_op_o), .done_o(done_o),
    .carry_o(carry_o), .status_o(status_o), .clr_we_o(clr_we_o)
);

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] op_i = 2'd0;
    logic       we_i = 1'b0;
    logic       irq_i = 1'b0;
    logic       stall_o, done_o, carry_o, clr_we_o;
    logic [1:0] arr_op_o, status_o;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    flash_op_seq u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .we_i(we_i),
        .irq_i(irq_i), .stall_o(stall_o), .arr_op_o(arr_op_o), .done_o(done_o),
        .carry_o(carry_o), .status_o(status_o), .clr_we_o(clr_we_o)
    );

    function automatic int exp_len(input logic [1:0] op);
        return (op == 2'd0) ? 40 : (op == 2'd1) ? 12 : 6;
    endfunction

    function automatic logic exp_wr(input logic [1:0] op);
        return op[1] == 1'b0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // irq_at: 0 = none, else stall cycle (1-based) in which irq is raised
    task automatic run_op(input logic [1:0] op, input logic we, input int irq_at,
                          input logic noise);
        int len, cyc, exp_cyc;
        logic rej, abrt;
        len  = exp_len(op);
        rej  = exp_wr(op) && !we;
        abrt = !rej && irq_at > 0 && irq_at <= len;
        exp_cyc = rej ? 0 : (abrt ? irq_at : len);
        @(negedge clk);
        op_i = op; we_i = we; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (stall_o && cyc < 100) begin
            cyc++;
            chk("R6 carry/status clear in stall", {carry_o, status_o}, 0);
            chk("R10 arr_op during stall", arr_op_o, op);
            if (noise && cyc == 2) begin start_i = 1'b1; op_i = ~op; we_i = 1'b1; end
            else start_i = 1'b0;
            irq_i = (cyc == irq_at);
            @(negedge clk);
        end
        start_i = 1'b0; irq_i = 1'b0;
        chk(noise ? "R8 stall length with ignored start" : "R2 stall length", cyc, exp_cyc);
        chk("R3 done pulse at end", done_o, 1);
        chk(rej ? "R5 carry" : (abrt ? "R4 carry" : "R3 carry"), carry_o, (rej || abrt) ? 1 : 0);
        chk(rej ? "R5 status" : (abrt ? (irq_at == len ? "R9 last-cycle abort status" : "R4 status") : "R3 status"),
            status_o, rej ? 2 : (abrt ? 1 : 0));
        chk("R7 clear write enable pulse", clr_we_o, (!rej && exp_wr(op)) ? 1 : 0);
        @(negedge clk);
        chk("R3 done one cycle", done_o, 0);
        chk("R7 clear pulse one cycle", clr_we_o, 0);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed, c0, s0;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 stall in reset", stall_o, 0);
        chk("R1 done/carry/clr in reset", {done_o, carry_o, clr_we_o}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1 status after reset", status_o, 0);
        chk("R1 stall after reset", stall_o, 0);

        // directed
        run_op(2'd0, 1'b1, 0, 1'b0);     // R2 erase
        run_op(2'd1, 1'b1, 0, 1'b0);     // R2 program
        run_op(2'd2, 1'b1, 0, 1'b0);     // R2 crc
        run_op(2'd3, 1'b0, 0, 1'b0);     // R2 crc alias, no WE needed
        run_op(2'd0, 1'b0, 0, 1'b0);     // R5 erase rejected
        run_op(2'd1, 1'b0, 3, 1'b0);     // R5 program rejected
        run_op(2'd1, 1'b1, 1, 1'b0);     // R4 abort first cycle
        run_op(2'd1, 1'b1, 12, 1'b0);    // R9 abort last cycle
        run_op(2'd2, 1'b1, 6, 1'b0);     // R9 crc last cycle, no clear
        run_op(2'd0, 1'b1, 0, 1'b1);     // R8 ignored start

        // R9 idle irq leaves result unchanged
        c0 = carry_o; s0 = status_o;
        @(negedge clk); irq_i = 1'b1;
        @(negedge clk); irq_i = 1'b0;
        @(negedge clk);
        chk("R9 idle irq carry", carry_o, c0);
        chk("R9 idle irq status", status_o, s0);
        chk("R9 idle irq stall", stall_o, 0);

        // random
        for (int i = 0; i < 60; i++) begin
            logic [1:0] op;
            logic we, nz;
            int ia;
            op = 2'($urandom_range(0, 3));
            we = ($urandom_range(0, 3) != 0);
            ia = ($urandom_range(0, 1) != 0) ? $urandom_range(1, exp_len(op)) : 0;
            nz = ($urandom_range(0, 3) == 0);
            run_op(op, we, ia, nz);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule